// File: doc/BRIEF.md
# Spanning-Tree Port-State Table

This block holds the per-port forwarding states of up to 64 spanning-tree instances. Each instance is addressed by a 6-bit instance number. Each stored entry is a valid flag plus a 2-bit state for every switch port.

The host drives one command at a time through a start pulse, an opcode, an instance number, a valid bit and a packed data word. The block offers four operations:

- **Load:** writes an entry.
- **Purge:** a load with the valid bit clear, which removes the entry.
- **Flush:** clears every entry at once.
- **Get-next:** searches upward from the given instance number for the next valid instance and returns it.

A neighbouring VLAN membership table shares the same packed data word and the same one-command-at-a-time interlock. That table is outside this block. It is represented only by its busy input.

The packed data word has one 4-bit slot per port. Bits 1:0 of a slot carry the VLAN membership tag, which belongs to the neighbour. Bits 3:2 carry the port state, which belongs to this table.

Software reads one exact instance by running get-next from that number minus one. It then compares the returned number and checks the valid flag. When loading both tables, the host loads the instance entry here first, then the VLAN entry that points at it.

Top module: `stu_table`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `rsp_sid` and `rsp_data` are all zero, and no instance is valid.
- R2: A command is accepted when `cmd_start` is high, `cmd_op` is nonzero, `busy` is low and `vlan_busy` is low. An accepted command makes `busy` high in the next cycle, and `busy` returns low within 66 cycles. Opcodes: 0 = none, 1 = load/purge, 2 = get-next, 3 = flush.
- R3: A start pulse while `busy` or `vlan_busy` is high has no effect on any stored entry.
- R4: A load with `cmd_valid` = 1 stores, for instance `cmd_sid`, the state of each port p. That state is taken from `cmd_data` bits [16*(p/4)+4*(p%4)+2 +: 2].
- R5: A load with `cmd_valid` = 0 removes instance `cmd_sid`, so later get-next searches skip it.
- R6: Get-next from s returns the smallest valid instance greater than s in `rsp_sid`, with `rsp_valid` = 1. That instance's states appear in `rsp_data`, laid out as in R4.
- R7: Get-next started from n-1 returns instance n with `rsp_valid` = 1 exactly when n is valid.
- R8: A get-next that finds no valid instance above its start (including a start of 63) gives `rsp_valid` = 0, `rsp_sid` = 63 and `rsp_data` all zero.
- R9: Flush invalidates every instance.
- R10: The membership-tag bits (bits 1:0 of each slot) of `cmd_data` are ignored, and the same bits of `rsp_data` are always zero.
- R11: `rsp_valid`, `rsp_sid` and `rsp_data` change only in the cycle in which `busy` falls. Load, purge and flush leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vlan_busy | input | 1 | Neighbouring VLAN table is executing a command |
| cmd_start | input | 1 | Start pulse for a command |
| cmd_op | input | 2 | Opcode: 0 none, 1 load/purge, 2 get-next, 3 flush |
| cmd_sid | input | 6 | Instance number (start point for get-next) |
| cmd_valid | input | 1 | Load when 1, purge when 0 |
| cmd_data | input | 48 | Packed per-port slots; state in bits 3:2 of each slot |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | Last get-next found an instance |
| rsp_sid | output | 6 | Instance number returned by the last get-next |
| rsp_data | output | 48 | Port states of the returned instance, tag bits zero |

## Verification
The assertions check the following on every cycle:

- The busy handshake: an accepted start raises `busy`, and `busy` is bounded in length.
- A start is rejected while the VLAN table is busy.
- The zeroed tag bits.
- The all-zero data on a miss.
- The rule that response outputs move only as `busy` falls.

Only the bench scenarios can show table contents:

- That get-next skips purged and flushed instances.
- That the exact-read idiom lands on the right entry.
- That a command issued during a scan leaves the table untouched.
- That each port's state comes back in its own slot.

// File: rtl/stu_pkg.sv
package stu_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_NEXT  = 2'd2,
    OP_FLUSH = 2'd3
  } stu_op_e;

  localparam int SLOT_W    = 4;
  localparam int SLOTS_REG = 4;
  localparam int REG_W     = SLOT_W * SLOTS_REG;
  localparam int STATE_LSB = 2;
endpackage

// File: rtl/stu_lane_map.sv
module stu_lane_map #(
  parameter int NPORTS = 11,
  parameter int DW     = 48,
  parameter int SW     = 22
) (
  input  logic [DW-1:0] packed_in,
  output logic [SW-1:0] states_out,
  input  logic [SW-1:0] states_in,
  output logic [DW-1:0] packed_out
);
  import stu_pkg::*;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam int OFF = REG_W * (p / SLOTS_REG) + SLOT_W * (p % SLOTS_REG) + STATE_LSB;
    assign states_out[2*p +: 2] = packed_in[OFF +: 2];
  end

  always_comb begin
    packed_out = '0;
    for (int p = 0; p < NPORTS; p++) begin
      packed_out[REG_W*(p/SLOTS_REG) + SLOT_W*(p%SLOTS_REG) + STATE_LSB +: 2] = states_in[2*p +: 2];
    end
  end
endmodule

// File: rtl/stu_state_ram.sv
module stu_state_ram #(
  parameter int AW = 6,
  parameter int W  = 22
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stu_seq.sv
module stu_seq #(
  parameter int SID_W = 6,
  parameter int SW    = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vlan_busy,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [SID_W-1:0] sid,
  input  logic             vbit,
  input  logic [SW-1:0]    wstates,
  output logic             ram_we,
  output logic [SID_W-1:0] ram_waddr,
  output logic [SW-1:0]    ram_wdata,
  output logic [SID_W-1:0] ram_raddr,
  input  logic [SW-1:0]    ram_rdata,
  output logic             busy,
  output logic             rsp_valid,
  output logic [SID_W-1:0] rsp_sid,
  output logic [SW-1:0]    rsp_states
);
  import stu_pkg::*;

  localparam int DEPTH = 1 << SID_W;
  localparam logic [SID_W-1:0] MAXSID = SID_W'(DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_FILL, S_MISS, S_DONE} st_e;

  st_e              state;
  logic [DEPTH-1:0] vld;
  logic [SID_W-1:0] ptr;
  stu_op_e          opc;
  logic             accept;

  assign opc       = stu_op_e'(op);
  assign accept    = start && (state == S_IDLE) && !vlan_busy && (opc != OP_NONE);
  assign ram_we    = accept && (opc == OP_LOAD) && vbit;
  assign ram_waddr = sid;
  assign ram_wdata = wstates;
  assign ram_raddr = ptr;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      vld        <= '0;
      ptr        <= '0;
      rsp_valid  <= 1'b0;
      rsp_sid    <= '0;
      rsp_states <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          case (opc)
            OP_LOAD:  begin vld[sid] <= vbit; state <= S_DONE; end
            OP_FLUSH: begin vld <= '0;        state <= S_DONE; end
            OP_NEXT: begin
              if (sid == MAXSID) state <= S_MISS;
              else begin
                ptr   <= sid + SID_W'(1);
                state <= S_SCAN;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
        S_SCAN: begin
          if (vld[ptr])            state <= S_FILL;
          else if (ptr == MAXSID)  state <= S_MISS;
          else                     ptr   <= ptr + SID_W'(1);
        end
        S_FILL: begin
          rsp_valid  <= 1'b1;
          rsp_sid    <= ptr;
          rsp_states <= ram_rdata;
          state      <= S_IDLE;
        end
        S_MISS: begin
          rsp_valid  <= 1'b0;
          rsp_sid    <= MAXSID;
          rsp_states <= '0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stu_table.sv
module stu_table #(
  parameter int NPORTS = 11,
  parameter int SID_W  = 6,
  localparam int NREG  = (NPORTS + 3) / 4,
  localparam int DW    = NREG * 16,
  localparam int SW    = NPORTS * 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vlan_busy,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_op,
  input  logic [SID_W-1:0] cmd_sid,
  input  logic             cmd_valid,
  input  logic [DW-1:0]    cmd_data,
  output logic             busy,
  output logic             rsp_valid,
  output logic [SID_W-1:0] rsp_sid,
  output logic [DW-1:0]    rsp_data
);
  logic [SW-1:0]    wstates, rsp_states, ram_wdata, ram_rdata;
  logic             ram_we;
  logic [SID_W-1:0] ram_waddr, ram_raddr;

  stu_lane_map #(.NPORTS(NPORTS), .DW(DW), .SW(SW)) u_map (
    .packed_in(cmd_data), .states_out(wstates),
    .states_in(rsp_states), .packed_out(rsp_data)
  );

  stu_state_ram #(.AW(SID_W), .W(SW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  stu_seq #(.SID_W(SID_W), .SW(SW)) u_seq (
    .clk(clk), .rst(rst), .vlan_busy(vlan_busy), .start(cmd_start),
    .op(cmd_op), .sid(cmd_sid), .vbit(cmd_valid), .wstates(wstates),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_sid(rsp_sid), .rsp_states(rsp_states)
  );
endmodule

// File: rtl/stu_table_chk.sv
module stu_table_chk #(
  parameter int NPORTS = 11,
  parameter int SID_W  = 6,
  localparam int NREG  = (NPORTS + 3) / 4,
  localparam int DW    = NREG * 16
) (
  input logic             clk,
  input logic             rst,
  input logic             vlan_busy,
  input logic             cmd_start,
  input logic [1:0]       cmd_op,
  input logic [SID_W-1:0] cmd_sid,
  input logic             cmd_valid,
  input logic [DW-1:0]    cmd_data,
  input logic             busy,
  input logic             rsp_valid,
  input logic [SID_W-1:0] rsp_sid,
  input logic [DW-1:0]    rsp_data
);
  localparam int LIMIT = (1 << SID_W) + 2;

  function automatic logic [DW-1:0] tag_mask();
    logic [DW-1:0] m = '0;
    for (int s = 0; s < DW / 4; s++) m[4*s +: 2] = 2'b11;
    return m;
  endfunction

  logic [15:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else              busy_run <= busy_run + 16'd1;
  end

  // R2: accepted start raises busy
  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !busy && !vlan_busy && cmd_op != 2'd0) |=> busy);

  // R2: busy is bounded
  assert_busy_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy_run <= 16'(LIMIT));

  // R3: VLAN table holds the shared interlock
  assert_vlan_lock_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && vlan_busy && !busy) |=> !busy);

  // R8: a miss returns zero data
  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_data == '0));

  // R10: tag bits never appear on the response
  assert_tag_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_data & tag_mask()) == '0);

  // R11: response moves only when busy falls
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rsp_sid) || !$stable(rsp_valid) || !$stable(rsp_data)) |-> $fell(busy));
endmodule

bind stu_table stu_table_chk #(.NPORTS(NPORTS), .SID_W(SID_W)) u_chk (.*);

// File: tb/stu_table_test.sv
module stu_table_test;
  localparam int NPORTS = 11;
  localparam int SID_W  = 6;
  localparam int DW     = 48;
  localparam int SW     = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vlan_busy = 1'b0;
  logic cmd_start = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [SID_W-1:0] cmd_sid = '0;
  logic cmd_valid = 1'b0;
  logic [DW-1:0] cmd_data = '0;
  logic busy, rsp_valid;
  logic [SID_W-1:0] rsp_sid;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  stu_table #(.NPORTS(NPORTS), .SID_W(SID_W)) uut (
    .clk(clk), .rst(rst), .vlan_busy(vlan_busy), .cmd_start(cmd_start),
    .cmd_op(cmd_op), .cmd_sid(cmd_sid), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_sid(rsp_sid), .rsp_data(rsp_data)
  );

  function automatic logic [DW-1:0] place(input logic [SW-1:0] st);
    logic [DW-1:0] d = '0;
    for (int p = 0; p < NPORTS; p++) d[16*(p/4) + 4*(p%4) + 2 +: 2] = st[2*p +: 2];
    return d;
  endfunction

  function automatic logic [DW-1:0] tags();
    logic [DW-1:0] d = '0;
    for (int s = 0; s < DW/4; s++) d[4*s +: 2] = 2'b11;
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Drive one command; expect_acc tells whether busy should rise.
  task automatic do_cmd(input logic [1:0] op, input logic [5:0] sid, input logic v,
                        input logic [DW-1:0] data, input bit expect_acc);
    @(negedge clk);
    cmd_op = op; cmd_sid = sid; cmd_valid = v; cmd_data = data; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(busy == expect_acc, "R2/R3 busy after start", 64'(busy), 64'(expect_acc));
    while (busy) @(negedge clk);
  endtask

  localparam logic [SW-1:0] A = 22'h123456;
  localparam logic [SW-1:0] B = 22'h3F00FF;
  localparam logic [SW-1:0] C = 22'h2DB6DB;
  localparam logic [SW-1:0] D = 22'h155555;

  // {op, sid, valid, states, exp_valid, exp_sid, exp_states}
  localparam int NV = 10;
  localparam logic [59:0] VEC [NV] = '{
    {2'd1, 6'd5,  1'b1, A,     1'b0, 6'd0,  22'd0},
    {2'd1, 6'd20, 1'b1, B,     1'b0, 6'd0,  22'd0},
    {2'd1, 6'd63, 1'b1, C,     1'b0, 6'd0,  22'd0},
    {2'd2, 6'd0,  1'b0, 22'd0, 1'b1, 6'd5,  A},
    {2'd2, 6'd5,  1'b0, 22'd0, 1'b1, 6'd20, B},
    {2'd2, 6'd20, 1'b0, 22'd0, 1'b1, 6'd63, C},
    {2'd2, 6'd63, 1'b0, 22'd0, 1'b0, 6'd63, 22'd0},
    {2'd1, 6'd20, 1'b0, 22'd0, 1'b0, 6'd0,  22'd0},
    {2'd2, 6'd5,  1'b0, 22'd0, 1'b1, 6'd63, C},
    {2'd2, 6'd4,  1'b0, 22'd0, 1'b1, 6'd5,  A}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    logic [SID_W-1:0] held_sid;
    logic [DW-1:0]    held_data;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !rsp_valid, "R1 busy/valid after reset", {busy, rsp_valid}, 0);
    chk(rsp_sid == 0 && rsp_data == 0, "R1 sid/data after reset", {rsp_sid, rsp_data}, 0);
    do_cmd(2'd2, 6'd0, 1'b0, '0, 1'b1);
    chk(!rsp_valid && rsp_sid == 6'd63, "R1 table empty after reset", {rsp_valid, rsp_sid}, {1'b0, 6'd63});

    // Vector table: loads carry junk in the tag bits (R10)
    for (int i = 0; i < NV; i++) begin
      logic [59:0] v;
      string tg;
      v = VEC[i];
      do_cmd(v[59:58], v[57:52], v[51], place(v[50:29]) | tags(), 1'b1);
      if (v[59:58] == 2'd2) begin
        if (!v[28])      tg = "R8 miss";
        else if (i == 9) tg = "R7 exact read";
        else if (i == 8) tg = "R5 purge skipped";
        else             tg = "R4/R6 next";
        chk(rsp_valid == v[28] && rsp_sid == v[27:22] && rsp_data == place(v[21:0]),
            tg, {rsp_valid, rsp_sid, rsp_data}, {v[28], v[27:22], place(v[21:0])});
      end
    end
    chk((rsp_data & tags()) == '0, "R10 tag bits zero", rsp_data, 0);

    // R11: load leaves the response untouched
    held_sid = rsp_sid; held_data = rsp_data;
    do_cmd(2'd1, 6'd40, 1'b1, place(D), 1'b1);
    chk(rsp_sid == held_sid && rsp_data == held_data && rsp_valid,
        "R11 response held over load", {rsp_sid, rsp_data}, {held_sid, held_data});

    // R9: flush clears all
    do_cmd(2'd3, 6'd0, 1'b0, '0, 1'b1);
    chk(rsp_sid == held_sid && rsp_valid, "R11 response held over flush", rsp_sid, held_sid);
    do_cmd(2'd2, 6'd0, 1'b0, '0, 1'b1);
    chk(!rsp_valid && rsp_sid == 6'd63 && rsp_data == 0, "R9 flush empties table",
        {rsp_valid, rsp_sid}, {1'b0, 6'd63});

    // R3: load while the VLAN table is busy is ignored
    vlan_busy = 1'b1;
    do_cmd(2'd1, 6'd10, 1'b1, place(D), 1'b0);
    vlan_busy = 1'b0;
    do_cmd(2'd2, 6'd9, 1'b0, '0, 1'b1);
    chk(!rsp_valid, "R3 load under vlan_busy ignored", rsp_valid, 0);

    do_cmd(2'd1, 6'd10, 1'b1, place(D), 1'b1);
    do_cmd(2'd2, 6'd9, 1'b0, '0, 1'b1);
    chk(rsp_valid && rsp_sid == 6'd10 && rsp_data == place(D), "R7 exact read of 10",
        {rsp_valid, rsp_sid, rsp_data}, {1'b1, 6'd10, place(D)});

    // R3: start during a running scan is ignored
    @(negedge clk);
    cmd_op = 2'd2; cmd_sid = 6'd0; cmd_start = 1'b1;
    @(negedge clk);
    cmd_op = 2'd1; cmd_sid = 6'd3; cmd_valid = 1'b1; cmd_data = place(A);
    @(negedge clk);
    cmd_start = 1'b0;
    while (busy) @(negedge clk);
    do_cmd(2'd2, 6'd2, 1'b0, '0, 1'b1);
    chk(rsp_valid && rsp_sid == 6'd10, "R3 load during busy ignored", rsp_sid, 6'd10);

    // R8: start at the top instance misses
    do_cmd(2'd2, 6'd63, 1'b0, '0, 1'b1);
    chk(!rsp_valid && rsp_sid == 6'd63 && rsp_data == 0, "R8 start at 63",
        {rsp_valid, rsp_sid}, {1'b0, 6'd63});

    finish_run();
  end
endmodule